// File: doc/BRIEF.md
# Multi-Step Register Rotate Unit

This block carries out the single-word repeated shift and rotate instructions of a 20-bit processor on one register operand. The instruction word names the operation, the operand width, the register being worked on and how many single-bit steps to take, from one to four. The register file supplies the operand value and the status logic supplies the incoming carry. The unit then performs one shift per clock. When the last step is done, it presents the shifted value for write-back, the final carry and the negative and zero flags.

A sequencer raises `start` for one cycle while the unit is idle, with the instruction word, operand and carry valid on that edge. `busy` stays high while steps are taken. `done` pulses for one cycle once the final step is in. The result and flags then hold until the next accepted start. A new start may be raised in the same cycle that `done` is high, so instructions can run back to back with no idle cycle.

Top module: `multi_rotate_unit`

## Requirements
- R1: The step count is one more than the value in instruction bits 11:10, so 00 gives one step and 11 gives four. Instruction bits 3:0 are returned unchanged on `regSel` from the accepted start onward.
- R2: Operation code 00 in bits 9:8 rotates right through carry. Each step moves the old carry into the top bit of the active width.
- R3: Operation code 01 is an arithmetic right shift. Each step keeps the top bit of the active width unchanged.
- R4: Operation code 10 shifts left by one per step, fills bit 0 with zero and drops anything carried past the top of the active width.
- R5: Operation code 11 is a logical right shift. Each step fills the top bit of the active width with zero.
- R6: Instruction bit 4 clear selects 20-bit width. Bit 4 set selects 16-bit width, in which operand bits 19:16 are disregarded and result bits 19:16 read zero.
- R7: `carryIn` is captured at the accepted start. Each step replaces the carry with the bit shifted out: bit 0 for right shifts, or the top bit of the active width for the left shift.
- R8: After the final step, `negFlag` equals the top bit of the active width of the result, and `zeroFlag` is high exactly when the result is zero.
- R9: A start is accepted on a clock edge where `busy` is low. `busy` is then high for n cycles. `done` is high for exactly the one cycle after the n-th step, and result and flags hold after that.
- R10: A start raised while `busy` is high has no effect on the running instruction's count, result, carry or flags.
- R11: A start raised in the cycle where `done` is high is accepted, and the new instruction begins at once.
- R12: During reset and after it, `busy`, `done`, `result`, `carryOut`, `negFlag`, `zeroFlag` and `regSel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction when idle |
| instrWord | input | 16 | Instruction word carrying count, operation, width and register fields |
| opValue | input | 20 | Register operand value |
| carryIn | input | 1 | Carry flag before the instruction |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse after the last step |
| result | output | 20 | Shifted value, zero above the active width |
| regSel | output | 4 | Register number for write-back |
| carryOut | output | 1 | Carry after the most recent step |
| negFlag | output | 1 | Negative flag from the final result |
| zeroFlag | output | 1 | Zero flag from the final result |

## Verification
Two events can fall in the same cycle: the completion of one instruction and the acceptance of the next. To provoke this, the sweep raises `start` with a fresh instruction in the very cycle where `done` is high, on every third run. The bench judges the overlap in two ways. The finishing instruction's result, carry and flags must still be correct in that cycle. On the next cycle, `busy` must be high and the new instruction must go on to its own correct result. Stray starts raised while the unit is busy are also injected, to show that they neither restart nor disturb the running count.

// File: rtl/mrot_pkg.sv
`timescale 1ns/1ps
package mrot_pkg;
  // default geometry of the unit
  localparam int DATA_W   = 20;
  localparam int NARROW_W = 16;
  localparam int CNT_W    = 2;
  localparam int SEL_W    = 4;

  // instruction field positions that the sequencer relies on
  localparam int F_CNT_LO = 10;
  localparam int F_OP_LO  = 8;
  localparam int F_NARROW = 4;
  localparam int F_SEL_LO = 0;

  typedef enum logic [1:0] {
    OP_RRC = 2'b00,
    OP_RRA = 2'b01,
    OP_SLA = 2'b10,
    OP_RRU = 2'b11
  } shOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } strobe_t;
endpackage

// File: rtl/mrot_ctrl.sv
`timescale 1ns/1ps
module mrot_ctrl
  import mrot_pkg::*;
#(
  parameter int CNT_W = mrot_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] repField,
  output strobe_t          stb,
  output logic             busy,
  output logic             done
);
  // steps still to take after the current one
  logic [CNT_W-1:0] cntLeft;
  logic             accept;

  assign accept   = start && !busy;
  assign stb.load = accept;
  assign stb.step = busy;
  assign stb.last = busy && (cntLeft == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cntLeft <= '0;
    end else begin
      done <= stb.last;
      if (accept) begin
        busy    <= 1'b1;
        cntLeft <= repField;
      end else if (busy) begin
        if (cntLeft == '0) busy <= 1'b0;
        else               cntLeft <= cntLeft - 1'b1;
      end
    end
  end

  // R9: done never lasts more than one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: an accepted start loads the count field
  a_r1_count_load: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && cntLeft == $past(repField)));

  // R9: the last step is followed by done with the unit idle
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> (done && !busy));

  // R10: a start while busy does not reload the count
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && cntLeft != '0) |=> (busy && cntLeft < $past(cntLeft)));

  // R11: a start coinciding with done is taken
  a_r11_chain_accept: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> busy);
endmodule

// File: rtl/mrot_dpath.sv
`timescale 1ns/1ps
module mrot_dpath
  import mrot_pkg::*;
#(
  parameter int DATA_W   = mrot_pkg::DATA_W,
  parameter int NARROW_W = mrot_pkg::NARROW_W,
  parameter int SEL_W    = mrot_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] opValue,
  input  logic              carryIn,
  input  shOp_t             opSel,
  input  logic              narrowSel,
  input  logic [SEL_W-1:0]  regSelIn,
  output logic [DATA_W-1:0] result,
  output logic [SEL_W-1:0]  regSel,
  output logic              carryOut,
  output logic              negFlag,
  output logic              zeroFlag
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] WIDE_MASK   = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [IDX_W-1:0]  WIDE_TOP    = IDX_W'(DATA_W-1);
  localparam logic [IDX_W-1:0]  NARROW_TOP  = IDX_W'(NARROW_W-1);

  logic [DATA_W-1:0] shReg, nextVal, loadVal, actMask, fillVec;
  logic [SEL_W-1:0]  selReg;
  logic              cReg, nReg, zReg, narrowReg, outBit, topBit, fillBit;
  shOp_t             opReg;
  logic [IDX_W-1:0]  topIdx;

  assign actMask = narrowReg ? NARROW_MASK : WIDE_MASK;
  assign topIdx  = narrowReg ? NARROW_TOP : WIDE_TOP;
  assign topBit  = shReg[topIdx];
  assign loadVal = opValue & (narrowSel ? NARROW_MASK : WIDE_MASK);

  always_comb begin
    case (opReg)
      OP_RRC:  fillBit = cReg;
      OP_RRA:  fillBit = topBit;
      default: fillBit = 1'b0;
    endcase
    fillVec = {{(DATA_W-1){1'b0}}, fillBit} << topIdx;
    if (opReg == OP_SLA) begin
      outBit  = topBit;
      nextVal = (shReg << 1) & actMask;
    end else begin
      outBit  = shReg[0];
      nextVal = ((shReg >> 1) | fillVec) & actMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      selReg    <= '0;
      cReg      <= 1'b0;
      nReg      <= 1'b0;
      zReg      <= 1'b0;
      narrowReg <= 1'b0;
      opReg     <= OP_RRC;
    end else if (stb.load) begin
      shReg     <= loadVal;
      selReg    <= regSelIn;
      cReg      <= carryIn;
      narrowReg <= narrowSel;
      opReg     <= opSel;
    end else if (stb.step) begin
      shReg <= nextVal;
      cReg  <= outBit;
      if (stb.last) begin
        nReg <= nextVal[topIdx];
        zReg <= (nextVal == '0);
      end
    end
  end

  assign result   = shReg;
  assign regSel   = selReg;
  assign carryOut = cReg;
  assign negFlag  = nReg;
  assign zeroFlag = zReg;

  // R6: narrow operands keep the upper bits clear
  a_r6_narrow_upper: assert property (@(posedge clk) disable iff (!rstN)
    narrowReg |-> (shReg[DATA_W-1:NARROW_W] == '0));

  // R7: right shifts hand bit 0 to the carry
  a_r7_carry_lsb: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && opReg != OP_SLA) |=> (cReg == $past(shReg[0])));

  // R4: the left shift hands the top bit to the carry
  a_r4_carry_top: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && opReg == OP_SLA) |=> (cReg == $past(topBit)));

  // R5: the logical right shift leaves the top bit clear
  a_r5_top_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && opReg == OP_RRU) |=> (shReg[topIdx] == 1'b0));

  // R8: flags describe the held result
  a_r8_flags: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> (zReg == (shReg == '0) && nReg == shReg[topIdx]));
endmodule

// File: rtl/multi_rotate_unit.sv
`timescale 1ns/1ps
module multi_rotate_unit
  import mrot_pkg::*;
#(
  parameter int DATA_W   = mrot_pkg::DATA_W,
  parameter int NARROW_W = mrot_pkg::NARROW_W,
  parameter int CNT_W    = mrot_pkg::CNT_W,
  parameter int SEL_W    = mrot_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       instrWord,
  input  logic [DATA_W-1:0] opValue,
  input  logic              carryIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic [SEL_W-1:0]  regSel,
  output logic              carryOut,
  output logic              negFlag,
  output logic              zeroFlag
);
  strobe_t stb;
  logic    unusedBits;

  assign unusedBits = ^{instrWord[15:12], instrWord[7:5]};

  mrot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .repField (instrWord[F_CNT_LO +: CNT_W]),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  mrot_dpath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .SEL_W(SEL_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .opValue   (opValue),
    .carryIn   (carryIn),
    .opSel     (shOp_t'(instrWord[F_OP_LO +: 2])),
    .narrowSel (instrWord[F_NARROW]),
    .regSelIn  (instrWord[F_SEL_LO +: SEL_W]),
    .result    (result),
    .regSel    (regSel),
    .carryOut  (carryOut),
    .negFlag   (negFlag),
    .zeroFlag  (zeroFlag)
  );
endmodule

// File: tb/multi_rotate_unit_bench.sv
`timescale 1ns/1ps
module multi_rotate_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instrWord = '0;
  logic [19:0] opValue = '0;
  logic        carryIn = 1'b0;
  logic        busy, done, carryOut, negFlag, zeroFlag;
  logic [19:0] result;
  logic [3:0]  regSel;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  multi_rotate_unit u_multi_rotate_unit (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .opValue(opValue), .carryIn(carryIn), .busy(busy), .done(done),
    .result(result), .regSel(regSel), .carryOut(carryOut),
    .negFlag(negFlag), .zeroFlag(zeroFlag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // returns {neg, zero, carry, value} from the requirement text
  function automatic logic [22:0] model(input logic [15:0] iw, input logic [19:0] v, input logic c);
    int w = iw[4] ? 16 : 20;
    int n = int'(iw[11:10]) + 1;
    logic [19:0] mask = iw[4] ? 20'h0FFFF : 20'hFFFFF;
    logic [19:0] x = v & mask;
    logic cy = c;
    for (int k = 0; k < n; k++) begin
      logic co, fill;
      if (iw[9:8] == 2'b10) begin
        co = x[w-1];
        x  = (x << 1) & mask;
      end else begin
        co = x[0];
        fill = (iw[9:8] == 2'b00) ? cy : (iw[9:8] == 2'b01) ? x[w-1] : 1'b0;
        x = ((x >> 1) | (20'(fill) << (w-1))) & mask;
      end
      cy = co;
    end
    return {x[w-1], (x == 20'h0), cy, x};
  endfunction

  function automatic logic [19:0] pattern(input int idx);
    case (idx)
      0: return 20'h00000;
      1: return 20'hFFFFF;
      2: return 20'h80001;
      3: return 20'h12345;
      4: return 20'hA5A5A;
      5: return 20'h08000;
      default: return 20'h00001;
    endcase
  endfunction

  task automatic drive(input logic [15:0] iw, input logic [19:0] v, input logic c);
    instrWord = iw; opValue = v; carryIn = c; start = 1'b1;
  endtask

  // called at the negedge where start is raised; returns at the negedge where done is high
  task automatic track(input logic [15:0] iw, input logic [19:0] v, input logic c,
                       input bit garbage, input bit chained);
    logic [22:0] e = model(iw, v, c);
    int n = int'(iw[11:10]) + 1;
    @(negedge clk);
    start = 1'b0;
    if (chained) chk(busy === 1'b1, "R11 start during done accepted", 32'(busy), 1);
    else         chk(busy === 1'b1 && done === 1'b0, "R9 busy after start", 32'({busy, done}), 32'b10);
    chk(regSel === iw[3:0], "R1 register select", 32'(regSel), 32'(iw[3:0]));
    if (garbage && n >= 2) begin
      instrWord = ~iw; opValue = ~v; carryIn = ~c; start = 1'b1;
    end
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k < n) begin
        chk(busy === 1'b1 && done === 1'b0, "R1 R9 still stepping", 32'({busy, done}), 32'b10);
      end else begin
        chk(busy === 1'b0 && done === 1'b1, "R1 R9 done after n steps", 32'({busy, done}), 32'b01);
        chk(result === e[19:0], garbage ? "R10 R2 R3 R4 R5 R6 result" : "R2 R3 R4 R5 R6 result",
            32'(result), 32'(e[19:0]));
        chk(carryOut === e[20], "R7 carry", 32'(carryOut), 32'(e[20]));
        chk(zeroFlag === e[21], "R8 zero flag", 32'(zeroFlag), 32'(e[21]));
        chk(negFlag === e[22], "R8 negative flag", 32'(negFlag), 32'(e[22]));
        chk(regSel === iw[3:0], "R1 register select held", 32'(regSel), 32'(iw[3:0]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int run = 0;
    repeat (3) @(negedge clk);
    chk({busy, done, result, regSel, carryOut, negFlag, zeroFlag} === '0,
        "R12 outputs in reset", 32'({busy, done, carryOut, negFlag, zeroFlag}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, done, result, regSel, carryOut, negFlag, zeroFlag} === '0,
        "R12 outputs after reset", 32'(result), 0);

    // fixed case: rotate register 5 right through carry three times, 20-bit
    drive(16'h0845, 20'h12345, 1'b1);
    track(16'h0845, 20'h12345, 1'b1, 1'b0, 1'b0);
    chk(regSel === 4'd5, "R1 register 5", 32'(regSel), 5);
    @(negedge clk);

    for (int op = 0; op < 4; op++)
      for (int cnt = 0; cnt < 4; cnt++)
        for (int nar = 0; nar < 2; nar++)
          for (int p = 0; p < 7; p++)
            for (int c = 0; c < 2; c++) begin
              logic [15:0] iw;
              logic [19:0] v = pattern(p) ^ (20'(run) << 7);
              bit chainNext = (run % 3 == 0);
              iw = {4'h0, 2'(cnt), 2'(op), 3'b000, 1'(nar), 4'(run)};
              drive(iw, v, 1'(c));
              track(iw, v, 1'(c), (run % 2 == 1), (run % 3 == 1));
              if (!chainNext) begin
                logic [22:0] e = model(iw, v, 1'(c));
                @(negedge clk);
                chk(done === 1'b0 && result === e[19:0], "R9 done single and result held",
                    32'({done, result}), 32'(e[19:0]));
              end
              run++;
            end
    @(negedge clk);
    chk(busy === 1'b0, "R9 idle at end", 32'(busy), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule